// File: doc/BRIEF.md
# Collision Signaller with Post-Transmit Heartbeat

This block produces the signal-quality-error indication for a twisted-pair medium attachment unit facing an attachment-unit interface. A collision exists when the transmit side and the receive side are both active. In that case, and whenever the jabber guard requests it, the block drives a gated 10 MHz square wave on its collision output. The same output also carries a short heartbeat burst that follows each transmission, so the attached station can confirm that the collision path works. A strap input turns the heartbeat off.

The block also tells the loopback multiplexer which data to return to the station. This is transmit data normally and received twisted-pair data during a collision. It extends short collision, transmit and receive events into long active-low LED pulses so they stay visible. All timing is counted in cycles of the block clock. At the default 50 MHz clock, the oscillator period is 5 cycles, the heartbeat starts about 1.1 µs after transmit ends and lasts 1.0 µs, and the LED hold is 100 ms.

Top module: `sqe_coll_sig`

## Requirements
- R1: While rst_ni is low, and right after it is asserted at any time, coll_o and loop_rx_o are 0 and led_coll_no, led_tx_no and led_rx_no are 1 (off).
- R2: When tx_act_i and rx_act_i are both high, coll_o starts toggling no later than the second rising clock edge after the inputs change (40 ns, far below the 900 ns limit).
- R3: While enabled, coll_o repeats 3 cycles high and 2 cycles low (period OSC_DIV=5 cycles, 10 MHz at 50 MHz, 60 % duty). A burst always starts with the high phase. coll_o is 0 whenever no collision, jabber or heartbeat is present.
- R4: When either tx_act_i or rx_act_i drops while the other stays high, coll_o is 0 from the second rising edge on, and loop_rx_o is 0 from the first.
- R5: A high jab_i makes coll_o toggle within two edges, with or without transmit or receive activity and whatever the strap value.
- R6: With sqe_en_i high, a falling tx_act_i starts a heartbeat: coll_o toggles after a delay of HB_DLY+2 cycles (0.6 to 1.6 µs) for a burst of HB_LEN cycles (0.5 to 1.5 µs).
- R7: With sqe_en_i low, no heartbeat follows a transmission. Collisions and jabber are still signalled.
- R8: If tx_act_i rises again while a heartbeat is waiting or bursting, the heartbeat is cancelled and coll_o is 0 from the third edge on.
- R9: The LEDs are active low. Each turns on by the second edge after its event begins and stays on for LED_HOLD cycles after the event ends. The events are: collision or jabber for led_coll_no, tx_act_i for led_tx_no, and rx_act_i for led_rx_no.
- R10: Every new event reloads the hold time, so repeated events with gaps shorter than LED_HOLD, or continuous activity, keep the LED on without a break.
- R11: loop_rx_o is 1 exactly while a collision (tx_act_i and rx_act_i both high) was present at the previous edge. Transmit alone, receive alone and jabber leave it 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, 50 MHz nominal |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_act_i | input | 1 | Transmit activity on the twisted pair |
| rx_act_i | input | 1 | Receive activity (unsquelched) on the twisted pair |
| jab_i | input | 1 | Jabber guard requests collision signalling |
| sqe_en_i | input | 1 | Strap: 1 enables the post-transmit heartbeat |
| coll_o | output | 1 | Gated 10 MHz collision signal toward the interface driver |
| loop_rx_o | output | 1 | 1 selects received data for loopback, 0 selects transmit data |
| led_coll_no | output | 1 | Stretched collision/jabber LED, active low |
| led_tx_no | output | 1 | Stretched transmit LED, active low |
| led_rx_no | output | 1 | Stretched receive LED, active low |

## Verification
The assertions check on every cycle that loopback selection tracks the collision condition one edge late, that a high run of coll_o never exceeds three cycles, and that a lasting collision always shows a high pulse within any three cycles. They also check that coll_o stays quiet when none of its three sources is present, and that the transmit LED lights two edges after activity. Only the bench scenarios can show the heartbeat delay and length windows and its cancellation by a new transmission. The same holds for the strap disabling it, the exact 6-of-10 duty pattern, the full LED hold length and retriggering over gaps. Recovery from a mid-collision reset is also covered only by the bench.

// File: rtl/sqe_pkg.sv
package sqe_pkg;
  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_BURST = 2'd2
  } hb_state_e;

  localparam int unsigned LED_COL = 0;
  localparam int unsigned LED_TX  = 1;
  localparam int unsigned LED_RX  = 2;
  localparam int unsigned LED_NUM = 3;

  // bits needed to hold values 0..n-1
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/sqe_gated_osc.sv
module sqe_gated_osc #(
  parameter int unsigned DIV  = 5,
  parameter int unsigned HIGH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic osc_o
);
  localparam int unsigned PW = sqe_pkg::cnt_w(DIV);
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);
  localparam logic [PW-1:0] HI   = PW'(HIGH);

  logic [PW-1:0] ph_q;
  logic          osc_q;

  // phase restarts at 0 whenever disabled, so each burst opens high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      osc_q <= 1'b0;
    end else if (en_i) begin
      osc_q <= (ph_q < HI);
      ph_q  <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
    end else begin
      ph_q  <= '0;
      osc_q <= 1'b0;
    end
  end

  assign osc_o = osc_q;
endmodule

// File: rtl/sqe_heartbeat.sv
module sqe_heartbeat
  import sqe_pkg::*;
#(
  parameter int unsigned DLY = 55,
  parameter int unsigned LEN = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_i,
  input  logic arm_i,
  output logic burst_o
);
  localparam int unsigned MAXC = (DLY > LEN) ? DLY : LEN;
  localparam int unsigned CW   = cnt_w(MAXC);
  localparam logic [CW-1:0] DLY_LAST = CW'(DLY - 1);
  localparam logic [CW-1:0] LEN_LAST = CW'(LEN - 1);

  hb_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic          tx_d_q;
  logic          tx_fall;

  assign tx_fall = tx_d_q & ~tx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= HB_IDLE;
      cnt_q  <= '0;
      tx_d_q <= 1'b0;
    end else begin
      tx_d_q <= tx_i;
      unique case (st_q)
        HB_IDLE: begin
          if (tx_fall && arm_i) begin
            st_q  <= HB_WAIT;
            cnt_q <= '0;
          end
        end
        HB_WAIT: begin
          if (tx_i) begin
            st_q <= HB_IDLE;
          end else if (cnt_q == DLY_LAST) begin
            st_q  <= HB_BURST;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        HB_BURST: begin
          if (tx_i || cnt_q == LEN_LAST) st_q <= HB_IDLE;
          else                           cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= HB_IDLE;
      endcase
    end
  end

  assign burst_o = (st_q == HB_BURST);
endmodule

// File: rtl/sqe_led_stretch.sv
module sqe_led_stretch #(
  parameter int unsigned HOLD = 5_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  output logic led_no
);
  localparam int unsigned CW = sqe_pkg::cnt_w(HOLD + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD);

  logic [CW-1:0] cnt_q;

  // every event reloads the full hold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (ev_i)          cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign led_no = (cnt_q == '0);
endmodule

// File: rtl/sqe_coll_sig.sv
module sqe_coll_sig
  import sqe_pkg::*;
#(
  parameter int unsigned OSC_DIV  = 5,
  parameter int unsigned OSC_HIGH = 3,
  parameter int unsigned HB_DLY   = 55,
  parameter int unsigned HB_LEN   = 50,
  parameter int unsigned LED_HOLD = 5_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_act_i,
  input  logic rx_act_i,
  input  logic jab_i,
  input  logic sqe_en_i,
  output logic coll_o,
  output logic loop_rx_o,
  output logic led_coll_no,
  output logic led_tx_no,
  output logic led_rx_no
);
  logic tx_q, rx_q, jab_q, sqe_en_q;
  logic coll_act, hb_burst, osc_en;
  logic [LED_NUM-1:0] led_ev, led_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q     <= 1'b0;
      rx_q     <= 1'b0;
      jab_q    <= 1'b0;
      sqe_en_q <= 1'b0;
    end else begin
      tx_q     <= tx_act_i;
      rx_q     <= rx_act_i;
      jab_q    <= jab_i;
      sqe_en_q <= sqe_en_i;
    end
  end

  assign coll_act = tx_q & rx_q;
  assign osc_en   = coll_act | jab_q | hb_burst;

  sqe_heartbeat #(
    .DLY (HB_DLY),
    .LEN (HB_LEN)
  ) u_hb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tx_i    (tx_q),
    .arm_i   (sqe_en_q),
    .burst_o (hb_burst)
  );

  sqe_gated_osc #(
    .DIV  (OSC_DIV),
    .HIGH (OSC_HIGH)
  ) u_osc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (osc_en),
    .osc_o  (coll_o)
  );

  assign led_ev[LED_COL] = coll_act | jab_q;
  assign led_ev[LED_TX]  = tx_q;
  assign led_ev[LED_RX]  = rx_q;

  for (genvar i = 0; i < LED_NUM; i++) begin : g_led
    sqe_led_stretch #(
      .HOLD (LED_HOLD)
    ) u_led (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ev_i   (led_ev[i]),
      .led_no (led_n[i])
    );
  end

  assign loop_rx_o   = coll_act;
  assign led_coll_no = led_n[LED_COL];
  assign led_tx_no   = led_n[LED_TX];
  assign led_rx_no   = led_n[LED_RX];
endmodule

// File: rtl/sqe_coll_sig_chk.sv
module sqe_coll_sig_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_act_i,
  input logic rx_act_i,
  input logic jab_i,
  input logic coll_o,
  input logic loop_rx_o,
  input logic led_tx_no,
  input logic hb_burst
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  // R11
  loop_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd1) |-> (loop_rx_o == $past(tx_act_i && rx_act_i)));

  // R2
  coll_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && loop_rx_o && $past(loop_rx_o) && $past(loop_rx_o, 2))
    |-> (coll_o || $past(coll_o) || $past(coll_o, 2)));

  // R3
  high_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && coll_o && $past(coll_o) && $past(coll_o, 2)) |=> !coll_o);

  // R3
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && !$past(tx_act_i && rx_act_i, 2) && !$past(jab_i, 2)
     && !$past(hb_burst)) |-> !coll_o);

  // R9
  tx_led_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && $past(tx_act_i, 2)) |-> !led_tx_no);
endmodule

bind sqe_coll_sig sqe_coll_sig_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_act_i  (tx_act_i),
  .rx_act_i  (rx_act_i),
  .jab_i     (jab_i),
  .coll_o    (coll_o),
  .loop_rx_o (loop_rx_o),
  .led_tx_no (led_tx_no),
  .hb_burst  (hb_burst)
);

// File: tb/sim_sqe_coll_sig.sv
module sim_sqe_coll_sig;
  localparam int HOLD = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx = 1'b0, rx = 1'b0, jab = 1'b0, sqe = 1'b0;
  logic coll_o, loop_rx_o, led_coll_no, led_tx_no, led_rx_no;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  sqe_coll_sig #(.LED_HOLD(HOLD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tx_act_i(tx), .rx_act_i(rx), .jab_i(jab),
    .sqe_en_i(sqe), .coll_o(coll_o), .loop_rx_o(loop_rx_o),
    .led_coll_no(led_coll_no), .led_tx_no(led_tx_no), .led_rx_no(led_rx_no)
  );

  // {tx, rx, jab, expect toggling, expect loop_rx}
  localparam logic [4:0] VEC [10] = '{
    5'b00000, 5'b10000, 5'b01000, 5'b11011, 5'b00110,
    5'b10110, 5'b11111, 5'b01110, 5'b00000, 5'b11011
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hb_measure(output int dly, output int span);
    int first, last;
    tx = 1'b1; tick(20); tx = 1'b0;
    first = -1; last = -1;
    for (int k = 1; k <= 200; k++) begin
      tick(1);
      if (coll_o) begin
        if (first < 0) first = k;
        last = k;
      end
    end
    dly  = first;
    span = (first < 0) ? 0 : last - first + 1;
  endtask

  task automatic count_high(input int n, output int highs);
    highs = 0;
    for (int k = 0; k < n; k++) begin
      tick(1);
      if (coll_o) highs++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired (all requirements) act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int highs, rises, loop_bad, dly, span, n, offs;
    logic prev;

    // R1 reset state
    tick(3);
    chk("R1 coll in reset", int'(coll_o), 0);
    chk("R1 loop in reset", int'(loop_rx_o), 0);
    chk("R1 leds in reset", int'({led_coll_no, led_tx_no, led_rx_no}), 7);
    rst_n = 1'b1;
    tick(3);
    chk("R1 coll after release", int'(coll_o), 0);

    // table: R3 waveform, R5 jabber, R7 strap low, R11 loopback
    for (int i = 0; i < 10; i++) begin
      tx = VEC[i][4]; rx = VEC[i][3]; jab = VEC[i][2];
      tick(30);
      highs = 0; rises = 0; loop_bad = 0; prev = coll_o;
      for (int k = 0; k < 10; k++) begin
        tick(1);
        if (coll_o) highs++;
        if (coll_o && !prev) rises++;
        prev = coll_o;
        if (loop_rx_o != VEC[i][0]) loop_bad++;
      end
      chk($sformatf("R3 R5 highs vec%0d", i), highs, VEC[i][1] ? 6 : 0);
      chk($sformatf("R3 rises vec%0d", i), rises, VEC[i][1] ? 2 : 0);
      chk($sformatf("R11 loop vec%0d", i), loop_bad, 0);
    end
    tx = 0; rx = 0; jab = 0;
    tick(30);

    // R2 start latency, R4 stop latency (rx drops first)
    tx = 1; rx = 1;
    tick(1); chk("R11 loop on first edge", int'(loop_rx_o), 1);
    tick(1); chk("R2 coll by second edge", int'(coll_o), 1);
    tick(10);
    rx = 0;
    tick(1); chk("R4 loop off first edge", int'(loop_rx_o), 0);
    tick(1); chk("R4 coll off second edge", int'(coll_o), 0);
    count_high(8, highs); chk("R4 stays quiet", highs, 0);
    // R4 tx drops first
    rx = 1; tick(10);
    tx = 0;
    tick(2); chk("R4 coll off after tx idle", int'(coll_o), 0);
    rx = 0; tick(10);

    // R5 jabber latency
    jab = 1; tick(2); chk("R5 jab coll by second edge", int'(coll_o), 1);
    jab = 0; tick(10);

    // R7 no heartbeat with strap low
    sqe = 0; tick(2);
    hb_measure(dly, span);
    chk("R7 no heartbeat", dly, -1);

    // R6 heartbeat window: 30..80 cycles delay, 25..75 cycles burst
    sqe = 1; tick(2);
    hb_measure(dly, span);
    chk_rng("R6 heartbeat delay", dly, 30, 80);
    chk_rng("R6 heartbeat span", span, 25, 75);

    // R8 cancel while waiting
    tx = 1; tick(20); tx = 0; tick(30); tx = 1;
    count_high(100, highs);
    chk("R8 cancel in wait", highs, 0);
    tx = 0; tick(200);
    // R8 cancel during burst
    tx = 1; tick(20); tx = 0;
    n = 0;
    while (!coll_o && n < 100) begin tick(1); n++; end
    chk("R6 burst seen", int'(coll_o), 1);
    tx = 1; tick(2);
    count_high(10, highs);
    chk("R8 cancel in burst", highs, 0);
    sqe = 0; tx = 0; tick(200);

    // R9 LED timing
    tick(HOLD + 10);
    chk("R9 leds off when idle", int'({led_coll_no, led_tx_no, led_rx_no}), 7);
    tx = 1; tick(2); chk("R9 tx led on", int'(led_tx_no), 0);
    tick(1); tx = 0;
    n = 0;
    for (int k = 0; k < HOLD + 20; k++) begin tick(1); if (!led_tx_no) n++; end
    chk_rng("R9 tx led hold", n, HOLD - 1, HOLD + 2);
    rx = 1; tick(2); chk("R9 rx led on", int'(led_rx_no), 0);
    rx = 0;
    jab = 1; tick(1); jab = 0; tick(1);
    chk("R9 coll led on", int'(led_coll_no), 0);
    tick(HOLD + 10);
    chk("R9 leds off after hold", int'({led_coll_no, led_tx_no, led_rx_no}), 7);

    // R10 retrigger on pulses and continuous activity
    offs = 0;
    tx = 1; tick(2); tx = 0;
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 200; k++) begin tick(1); if (led_tx_no) offs++; end
      tx = 1; tick(2); if (led_tx_no) offs++; tx = 0;
    end
    chk("R10 pulses keep led on", offs, 0);
    tx = 1; offs = 0;
    for (int k = 0; k < 2 * HOLD; k++) begin tick(1); if (led_tx_no) offs++; end
    chk("R10 continuous keeps led on", offs, 0);
    tx = 0; tick(HOLD + 10);
    chk("R9 tx led off at end", int'(led_tx_no), 1);

    // R1 reset during a collision
    tx = 1; rx = 1; tick(20);
    rst_n = 1'b0; #1;
    chk("R1 coll cleared by reset", int'(coll_o), 0);
    chk("R1 loop cleared by reset", int'(loop_rx_o), 0);
    chk("R1 leds cleared by reset", int'({led_coll_no, led_tx_no, led_rx_no}), 7);
    tx = 0; rx = 0; tick(2);
    rst_n = 1'b1; tick(5);
    chk("R1 quiet after reset", int'(coll_o), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule